// File: doc/BRIEF.md
# Locked Atomic Read-Modify-Write Unit

This unit carries out one atomic memory operation at a time for a single requester against a shared, single-port memory. A command names an operation, a word address, a source operand and, for the conditional swap, an expected value. The unit raises a bus lock and waits for the arbiter to grant it. It reads the word, computes the new value and writes it back. It then drops the lock and reports the old memory value, plus a zero flag that shows whether a conditional swap succeeded. No other master may touch memory while the lock is high. This makes the read and the write one indivisible step.

Five operations are supported: increment, decrement, exchange, fetch-and-add and compare-and-exchange. Every operation, exchange included, always runs under the lock. The conditional swap always issues its write cycle, so every operation takes the same bus sequence: one locked read followed by one locked write.

The controller has five states. IDLE accepts a command with a legal opcode (transition "accept") and moves to LOCK_REQ. LOCK_REQ holds the lock and waits for the grant ("granted") before moving to READ. READ waits for the read acknowledge ("read acked") before moving to WRITE. WRITE waits for the write acknowledge ("write acked") before moving to DONE. DONE pulses the completion strobe and returns to IDLE unconditionally ("retire").

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset the unit is idle: `cmd_ready` is 1, and `mem_lock`, `mem_req` and `done` are 0.
- R2: A command is accepted only while `cmd_ready` is 1, which holds only in IDLE. All command fields are captured when the command is accepted, so later changes on the command inputs do not affect the running operation.
- R3: `mem_lock` rises in the cycle after acceptance and stays high through the read and the write. No memory request is made until `mem_gnt` has been seen. The lock is low in the cycle after the write acknowledge.
- R4: Each operation makes exactly one read and then exactly one write, both to the captured address.
- R5: Opcode 0 (increment) stores the old value plus 1, modulo 2^DW, and returns the old value.
- R6: Opcode 1 (decrement) stores the old value minus 1, modulo 2^DW, and returns the old value.
- R7: Opcode 2 (exchange) stores the operand and returns the old value.
- R8: Opcode 3 (fetch-and-add) stores the old value plus the operand, modulo 2^DW, and returns the old value.
- R9: Opcode 4 (compare-and-exchange) with expected value equal to memory sets `res_zf` to 1, stores the operand and returns the old value. For every other opcode `res_zf` is 0.
- R10: Opcode 4 with a mismatch clears `res_zf`, returns the memory value and still issues a write cycle that stores the unchanged value.
- R11: `done` is high for exactly one cycle per operation. `res_old` and `res_zf` are valid while `done` is high and hold until the next `done`.
- R12: Opcodes 5 to 7 are ignored. The unit stays in IDLE with `cmd_ready` high, `mem_lock` low and no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code (0 inc, 1 dec, 2 exchange, 3 fetch-add, 4 compare-exchange) |
| cmd_addr | input | AW | Word address of the target |
| cmd_operand | input | DW | Source operand |
| cmd_expect | input | DW | Expected value for compare-and-exchange |
| cmd_ready | output | 1 | Unit is idle and will take a legal command |
| mem_lock | output | 1 | Exclusive bus lock request/hold |
| mem_gnt | input | 1 | Arbiter grant of the locked bus |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with the read acknowledge |
| mem_ack | input | 1 | Access acknowledge |
| done | output | 1 | One-cycle completion strobe |
| res_old | output | DW | Memory value seen by the read |
| res_zf | output | 1 | Compare-and-exchange success flag |

## Verification
Several hundred random commands are spread over all five opcodes and a 16-word memory. Operands are random, and the expected value matches memory about half the time, so both outcomes of the conditional swap occur often. A competing master writes to random addresses whenever the lock is low, and memory latency varies. These runs separate a correct lock and grant order from one that lets the other master in, and a fixed write from one dropped on a failed swap. Directed cases cover increment at the all-ones value, decrement at zero, fetch-and-add overflow, and exact-match and off-by-one swaps. Further directed cases change the command inputs during an operation, which exposes a failure to capture them, and hold illegal opcodes, which must leave the unit untouched.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_INC  = 3'd0,
        OP_DEC  = 3'd1,
        OP_XCHG = 3'd2,
        OP_XADD = 3'd3,
        OP_CMPX = 3'd4
    } rmw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK_REQ,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } rmw_state_e;

    function automatic logic op_is_legal(input logic [OP_W-1:0] code);
        return code <= OP_W'(OP_CMPX);
    endfunction

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32
) (
    input  rmw_op_e         op,
    input  logic [DW-1:0]   old_val,
    input  logic [DW-1:0]   operand,
    input  logic [DW-1:0]   expect_val,
    output logic [DW-1:0]   new_val,
    output logic            zf
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic match;

    assign match = (old_val == expect_val);

    always_comb begin
        new_val = old_val;
        zf      = 1'b0;
        unique case (op)
            OP_INC:  new_val = old_val + ONE;
            OP_DEC:  new_val = old_val - ONE;
            OP_XCHG: new_val = operand;
            OP_XADD: new_val = old_val + operand;
            OP_CMPX: begin
                zf      = match;
                new_val = match ? operand : old_val;
            end
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
    import atomic_rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_legal,
    input  logic       mem_gnt,
    input  logic       mem_ack,
    output logic       cmd_ready,
    output logic       cmd_fire,
    output logic       mem_lock,
    output logic       mem_req,
    output logic       mem_we,
    output logic       rd_done,
    output logic       wr_done,
    output logic       done
);

    rmw_state_e state_q;
    rmw_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cmd_valid && cmd_legal) state_d = ST_LOCK_REQ;
            ST_LOCK_REQ: if (mem_gnt)                state_d = ST_READ;
            ST_READ:     if (mem_ack)                state_d = ST_WRITE;
            ST_WRITE:    if (mem_ack)                state_d = ST_DONE;
            ST_DONE:                                 state_d = ST_IDLE;
            default:                                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        cmd_ready = 1'b0;
        mem_lock  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:     cmd_ready = 1'b1;
            ST_LOCK_REQ: mem_lock  = 1'b1;
            ST_READ: begin
                mem_lock = 1'b1;
                mem_req  = 1'b1;
            end
            ST_WRITE: begin
                mem_lock = 1'b1;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
            end
            ST_DONE:     done      = 1'b1;
            default:     cmd_ready = 1'b0;
        endcase
    end

    assign cmd_fire = cmd_ready && cmd_valid && cmd_legal;
    assign rd_done  = (state_q == ST_READ)  && mem_ack;
    assign wr_done  = (state_q == ST_WRITE) && mem_ack;

endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_fire,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [DW-1:0]   cmd_operand,
    input  logic [DW-1:0]   cmd_expect,
    input  logic            rd_done,
    input  logic            wr_done,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [DW-1:0]   alu_new,
    input  logic            alu_zf,
    output rmw_op_e         op_q,
    output logic [DW-1:0]   old_q,
    output logic [DW-1:0]   operand_q,
    output logic [DW-1:0]   expect_q,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW-1:0]   res_old,
    output logic            res_zf
);

    logic [AW-1:0] addr_q;

    // command capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_INC;
            addr_q    <= '0;
            operand_q <= '0;
            expect_q  <= '0;
        end else if (cmd_fire) begin
            op_q      <= rmw_op_e'(cmd_op);
            addr_q    <= cmd_addr;
            operand_q <= cmd_operand;
            expect_q  <= cmd_expect;
        end
    end

    // memory word captured on the read acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       old_q <= '0;
        else if (rd_done) old_q <= mem_rdata;
    end

    // result registers, updated only when the write completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_old <= '0;
            res_zf  <= 1'b0;
        end else if (wr_done) begin
            res_old <= old_q;
            res_zf  <= alu_zf;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = alu_new;

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
    import atomic_rmw_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [DW-1:0]   cmd_operand,
    input  logic [DW-1:0]   cmd_expect,
    output logic            cmd_ready,
    output logic            mem_lock,
    input  logic            mem_gnt,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_ack,
    output logic            done,
    output logic [DW-1:0]   res_old,
    output logic            res_zf
);

    logic          cmd_legal;
    logic          cmd_fire;
    logic          rd_done;
    logic          wr_done;
    rmw_op_e       op_q;
    logic [DW-1:0] old_q;
    logic [DW-1:0] operand_q;
    logic [DW-1:0] expect_q;
    logic [DW-1:0] alu_new;
    logic          alu_zf;

    assign cmd_legal = op_is_legal(cmd_op);

    rmw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_legal (cmd_legal),
        .mem_gnt   (mem_gnt),
        .mem_ack   (mem_ack),
        .cmd_ready (cmd_ready),
        .cmd_fire  (cmd_fire),
        .mem_lock  (mem_lock),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .done      (done)
    );

    rmw_datapath #(.DW(DW), .AW(AW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_fire    (cmd_fire),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_operand (cmd_operand),
        .cmd_expect  (cmd_expect),
        .rd_done     (rd_done),
        .wr_done     (wr_done),
        .mem_rdata   (mem_rdata),
        .alu_new     (alu_new),
        .alu_zf      (alu_zf),
        .op_q        (op_q),
        .old_q       (old_q),
        .operand_q   (operand_q),
        .expect_q    (expect_q),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .res_old     (res_old),
        .res_zf      (res_zf)
    );

    rmw_alu #(.DW(DW)) u_alu (
        .op         (op_q),
        .old_val    (old_q),
        .operand    (operand_q),
        .expect_val (expect_q),
        .new_val    (alu_new),
        .zf         (alu_zf)
    );

endmodule

// File: rtl/atomic_rmw_checker.sv
module atomic_rmw_checker
    import atomic_rmw_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            cmd_ready,
    input logic            mem_lock,
    input logic            mem_gnt,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic            done
);

    AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);                                              // R3

    AST_REQ_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(mem_gnt) && $past(mem_lock));              // R3

    AST_LOCK_LOW_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_lock);                                                // R3

    AST_READY_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_lock && !done);                                  // R2

    AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_op <= 3'd4) |=> mem_lock && !cmd_ready); // R2

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> mem_req && mem_we);             // R4

    AST_WRITE_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> done);                           // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && cmd_ready);                                       // R11

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && cmd_op > 3'd4) |=> cmd_ready && !mem_lock); // R12

endmodule

bind atomic_rmw_unit atomic_rmw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .mem_lock  (mem_lock),
    .mem_gnt   (mem_gnt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .done      (done)
);

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/1ps
module atomic_rmw_unit_test;

    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_operand = '0;
    logic [DW-1:0] cmd_expect = '0;
    logic          cmd_ready;
    logic          mem_lock;
    logic          mem_gnt = 1'b0;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          done;
    logic [DW-1:0] res_old;
    logic          res_zf;

    always #2 clk = ~clk;   // 250 MHz

    atomic_rmw_unit #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_operand(cmd_operand), .cmd_expect(cmd_expect),
        .cmd_ready(cmd_ready), .mem_lock(mem_lock), .mem_gnt(mem_gnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done(done), .res_old(res_old), .res_zf(res_zf)
    );

    int unsigned vectors = 0;
    int unsigned errors  = 0;

    // bench memory, competing master and arbiter
    logic [DW-1:0] mem [DEPTH];
    int            other_busy = 0;
    bit            other_en   = 1'b1;
    int            wait_cnt   = 0;
    bit            in_op      = 1'b0;
    logic [AW-1:0] cur_addr   = '0;
    logic [DW-1:0] snap_old   = '0;
    int            rd_cnt = 0, wr_cnt = 0, bad_addr = 0, lock_gap = 0, intrude = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack    <= 1'b0;
            mem_gnt    <= 1'b0;
            other_busy = 0;
        end else begin
            if (other_busy > 0) other_busy = other_busy - 1;
            else if (other_en && !mem_lock && ($urandom % 4 == 0)) begin
                other_busy = 1 + int'($urandom % 3);
                mem[$urandom % DEPTH] = $urandom;
            end
            mem_gnt <= mem_lock && (other_busy == 0);
            if (mem_req && other_busy > 0) intrude++;
            if (in_op && !mem_lock && !done) lock_gap++;
            if (mem_ack) begin
                mem_ack  <= 1'b0;
                wait_cnt = int'($urandom % 3);
            end else if (mem_req) begin
                if (wait_cnt > 0) wait_cnt--;
                else begin
                    mem_ack <= 1'b1;
                    if (mem_addr != cur_addr) bad_addr++;
                    if (mem_we) begin
                        mem[mem_addr] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata <= mem[mem_addr];
                        snap_old  = mem[mem_addr];
                        if (wr_cnt != 0) bad_addr++;
                        rd_cnt++;
                    end
                end
            end
        end
    end

    function automatic logic [DW-1:0] exp_new(input logic [2:0] op, input logic [DW-1:0] old,
                                              input logic [DW-1:0] opd, input logic [DW-1:0] ex);
        case (op)
            3'd0: return old + 1;
            3'd1: return old - 1;
            3'd2: return opd;
            3'd3: return old + opd;
            default: return (old == ex) ? opd : old;
        endcase
    endfunction

    function automatic logic exp_zf(input logic [2:0] op, input logic [DW-1:0] old,
                                    input logic [DW-1:0] ex);
        return (op == 3'd4) && (old == ex);
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string op_req(input logic [2:0] op, input bit zf);
        case (op)
            3'd0: return "R5";
            3'd1: return "R6";
            3'd2: return "R7";
            3'd3: return "R8";
            default: return zf ? "R9" : "R10";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] opd, input logic [DW-1:0] ex);
        int n = 0;
        logic [DW-1:0] enew;
        logic          ezf;
        string         rq;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_operand = opd; cmd_expect = ex;
        cur_addr = a; rd_cnt = 0; wr_cnt = 0; bad_addr = 0; lock_gap = 0;
        @(negedge clk);
        in_op = 1'b1;
        check(cmd_ready == 1'b0 && mem_lock == 1'b1, "R2", {31'd0, cmd_ready}, 0);
        // R2: scramble the inputs after acceptance; the operation must ignore them
        cmd_valid = 1'b0; cmd_op = 3'd2; cmd_addr = ~a; cmd_operand = ~opd; cmd_expect = ~ex;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        in_op = 1'b0;
        check(n < 1000, "R3 watchdog", n, 1000);
        enew = exp_new(op, snap_old, opd, ex);
        ezf  = exp_zf(op, snap_old, ex);
        rq   = op_req(op, ezf);
        check(res_old == snap_old, rq, res_old, snap_old);
        check(res_zf == ezf, "R9", {31'd0, res_zf}, {31'd0, ezf});
        check(mem[a] == enew, rq, mem[a], enew);
        check(rd_cnt == 1 && wr_cnt == 1 && bad_addr == 0, "R4",
              rd_cnt * 16 + wr_cnt, 17);
        if (op == 3'd4) check(wr_cnt == 1, "R10", wr_cnt, 1);
        check(lock_gap == 0 && intrude == 0 && !mem_lock, "R3", lock_gap + intrude, 0);
        @(negedge clk);
        check(!done && res_old == snap_old && res_zf == ezf, "R11", res_old, snap_old);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; vectors++;
        $display("FAIL watchdog R3 actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < DEPTH; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cmd_ready && !mem_lock && !mem_req && !done, "R1",
              {28'd0, cmd_ready, mem_lock, mem_req, done}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_ready && !mem_lock && !done, "R1", {31'd0, cmd_ready}, 1);

        // directed corners with the competing master quiet
        other_en = 1'b0;
        repeat (4) @(negedge clk);
        mem[3] = 32'hFFFF_FFFF; run_op(3'd0, 4'd3, 32'h0, 32'h0);          // R5 wrap
        mem[4] = 32'h0;         run_op(3'd1, 4'd4, 32'h0, 32'h0);          // R6 wrap
        mem[5] = 32'hDEAD_BEEF; run_op(3'd2, 4'd5, 32'h1234_5678, 32'h0);  // R7
        mem[6] = 32'hF000_0001; run_op(3'd3, 4'd6, 32'h1000_0000, 32'h0);  // R8 overflow
        mem[7] = 32'h55;        run_op(3'd4, 4'd7, 32'hAA, 32'h55);        // R9 match
        mem[8] = 32'h55;        run_op(3'd4, 4'd8, 32'hAA, 32'h56);        // R10 off by one
        run_op(3'd4, 4'd8, 32'h1, 32'h55);                                 // R9 after failed swap

        // R12 illegal opcodes leave the unit idle
        for (int c = 5; c < 8; c++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 3'(c);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(cmd_ready && !mem_lock && !done, "R12",
                      {29'd0, cmd_ready, mem_lock, done}, 32'h4);
            end
            cmd_valid = 1'b0;
        end

        // constrained random mix with a competing master
        other_en = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [2:0]    op = 3'($urandom % 5);
            logic [AW-1:0] a  = AW'($urandom);
            logic [DW-1:0] ex = ($urandom % 2 == 0) ? mem[a] : DW'($urandom);
            run_op(op, a, DW'($urandom), ex);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule